// File: doc/BRIEF.md
# Quad Potentiometer Serial Command Front-End

This block is the slave side of a four-wire serial link that controls a bank of four digital potentiometers. It samples the serial clock, data in, active-low select and active-low pause inputs in the system clock domain. It then splits each select window into bytes, MSB first. The first byte names the device. The second carries the opcode, a register field and a pot field. Some commands take a third, data byte. Others instead open a stream of single-step moves.

The decoded fields go to a register-bank back end, which holds the wiper and stored settings. Write and transfer commands are committed with a single strobe when select rises, and only when the frame has the right number of bytes. For a read, the block takes the value from the back end and shifts it out. The serial output enable tells the pad when to drive. When the enable is low, the pin floats.

Top module: `spipot_front`

## Requirements
- R1: The first byte after select falls must be 0101 in bits 7..4, 00 in bits 3..2, and equal to `dev_addr` in bits 1..0. Any other first byte makes the rest of the window produce no strobe, no step and no output drive.
- R2: The second byte sets `cmd_op` from bits 7..4, `cmd_reg` from bits 3..2 and `cmd_pot` from bits 1..0. These outputs hold until the next instruction byte. At most one of `cmd_valid` and `step_pulse` is high in any cycle.
- R3: Opcodes 1101, 1110, 0001 and 1000 are transfers. After exactly two bytes, they raise `cmd_valid` for one cycle once select rises.
- R4: Opcodes 1010 and 1100 are writes. After three complete bytes, they raise `cmd_valid` for one cycle once select rises, with `cmd_data` equal to bits 5..0 of the third byte.
- R5: Opcodes 1001 and 1011 are reads. During the third byte, `so_en` is high and `so` presents 00 followed by `rd_data`, MSB first. Each bit is updated on a serial clock falling edge, so the host samples it on the next rising edge. Outside that byte, `so_en` is low.
- R6: The instruction byte 0101_0001 is a status read. Its third byte shifts out seven zeros followed by `wip`.
- R7: Opcode 0010 opens a stream. Every later serial clock rising edge produces one `step_pulse`, with `step_up` equal to the data-in level, until select rises.
- R8: Pause input falling while the serial clock is low freezes the frame. Clock edges are ignored and `so_en` is low. Pause input rising while the clock is low resumes the frame with no state lost.
- R9: After reset, nothing is accepted until select has been seen going from high to low.
- R10: Frames cut short, and undefined opcodes, produce no `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| dev_addr | input | 2 | Strapped device address |
| rd_data | input | 6 | Back-end value for selected pot/register |
| wip | input | 1 | Back-end write-in-progress flag |
| so | output | 1 | Serial data to host |
| so_en | output | 1 | Output driver enable (pin floats when low) |
| cmd_valid | output | 1 | One-cycle commit strobe |
| cmd_op | output | 4 | Opcode field |
| cmd_reg | output | 2 | Register select field |
| cmd_pot | output | 2 | Pot select field |
| cmd_data | output | 6 | Written data value |
| step_pulse | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 = toward high end |

## Verification
A frame state that has slipped by one bit shows up right away at the ports. The wrong byte gets decoded, so the committed opcode or pot is wrong, or a strobe is missing a few clocks after select rises. An off-by-one in the output shifter corrupts the very next bit the host samples. A stuck pause flag shows as an output enable that stays low, or as steps that never arrive within one serial clock period.

// File: rtl/spipot_pkg.sv
package spipot_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 6;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [3:0] ID_TYPE = 4'b0101;
  localparam logic [3:0] OP_GD2W = 4'b0001;
  localparam logic [3:0] OP_STEP = 4'b0010;
  localparam logic [3:0] OP_GW2D = 4'b1000;
  localparam logic [3:0] OP_RDW  = 4'b1001;
  localparam logic [3:0] OP_WRW  = 4'b1010;
  localparam logic [3:0] OP_RDD  = 4'b1011;
  localparam logic [3:0] OP_WRD  = 4'b1100;
  localparam logic [3:0] OP_D2W  = 4'b1101;
  localparam logic [3:0] OP_W2D  = 4'b1110;
  localparam logic [BYTE_W-1:0] STAT_BYTE = 8'b0101_0001;

  typedef enum logic [2:0] {F_IDLE, F_ID, F_INSTR, F_DATA, F_STEP, F_DONE, F_SKIP} frame_e;
  typedef enum logic [2:0] {K_BAD, K_XFER, K_WRITE, K_READ, K_STAT, K_STEP} kind_e;

  // Classify a complete instruction byte.
  function automatic kind_e op_kind(input logic [BYTE_W-1:0] ib);
    kind_e k;
    case (ib[7:4])
      OP_D2W, OP_W2D, OP_GD2W, OP_GW2D: k = K_XFER;
      OP_WRW, OP_WRD:                   k = K_WRITE;
      OP_RDW, OP_RDD:                   k = K_READ;
      OP_STEP:                          k = K_STEP;
      default:                          k = K_BAD;
    endcase
    if (ib == STAT_BYTE) k = K_STAT;
    return k;
  endfunction

  function automatic logic id_ok(input logic [BYTE_W-1:0] b, input logic [SEL_W-1:0] a);
    return (b[7:4] == ID_TYPE) && (b[3:2] == 2'b00) && (b[1:0] == a);
  endfunction

  function automatic logic [BYTE_W-1:0] out_byte(input logic stat, input logic wip,
                                                 input logic [DATA_W-1:0] d);
    return stat ? {{(BYTE_W-1){1'b0}}, wip} : {{(BYTE_W-DATA_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/spipot_sync.sv
module spipot_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spipot_edge.sv
module spipot_edge #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spipot_sodrv.sv
module spipot_sodrv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         so_bit
);
  logic [W-1:0] sh;
  logic         first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      first  <= 1'b1;
      so_bit <= 1'b0;
    end else if (!active) begin
      first <= 1'b1;
    end else if (shift) begin
      if (first) begin
        so_bit <= load_val[W-1];
        sh     <= {load_val[W-2:0], 1'b0};
        first  <= 1'b0;
      end else begin
        so_bit <= sh[W-1];
        sh     <= {sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spipot_front.sv
module spipot_front
  import spipot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic [SEL_W-1:0]  dev_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wip,
  output logic              so,
  output logic              so_en,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [SEL_W-1:0]  cmd_reg,
  output logic [SEL_W-1:0]  cmd_pot,
  output logic [DATA_W-1:0] cmd_data,
  output logic              step_pulse,
  output logic              step_up
);
  // Order {sck, si, cs_n, hold_n}; select resets as "low" so a held-low
  // select never looks like a fresh falling edge.
  localparam logic [3:0] PIN_RST = 4'b0001;

  logic [3:0] pins_s, pins_r, pins_f;
  logic sck_s, si_s, csn_s;
  logic sck_rise, sck_fall, cs_rise, cs_fall, hold_rise, hold_fall;
  logic sck_go, sck_fo, paused, commit, rd_active;
  frame_e st;
  kind_e  kind;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] nb;

  spipot_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, si, cs_n, hold_n}), .q(pins_s));

  spipot_edge #(.W(4), .RST_VAL(PIN_RST)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s), .rise(pins_r), .fall(pins_f));

  assign sck_s     = pins_s[3];
  assign si_s      = pins_s[2];
  assign csn_s     = pins_s[1];
  assign sck_rise  = pins_r[3];
  assign sck_fall  = pins_f[3];
  assign cs_rise   = pins_r[1];
  assign cs_fall   = pins_f[1];
  assign hold_rise = pins_r[0];
  assign hold_fall = pins_f[0];

  assign sck_go = sck_rise && !paused;
  assign sck_fo = sck_fall && !paused;
  assign nb     = {sh, si_s};

  // Pause tracking: only pause-pin edges seen while the clock is low count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      paused <= 1'b0;
    else if (csn_s)                  paused <= 1'b0;
    else if (hold_fall && !sck_s)    paused <= 1'b1;
    else if (hold_rise && !sck_s)    paused <= 1'b0;
  end

  // Frame sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; kind <= K_BAD; bitcnt <= '0; sh <= '0; commit <= 1'b0;
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_reg <= '0; cmd_pot <= '0;
      cmd_data <= '0; step_pulse <= 1'b0; step_up <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      step_pulse <= 1'b0;
      if (cs_rise) begin
        cmd_valid <= (st == F_DONE) && commit;
        st        <= F_IDLE;
      end else if (cs_fall) begin
        st <= F_ID; bitcnt <= '0; commit <= 1'b0;
      end else if (sck_go && st == F_STEP) begin
        step_pulse <= 1'b1;
        step_up    <= si_s;
      end else if (sck_go && (st == F_ID || st == F_INSTR || st == F_DATA)) begin
        sh     <= nb[BYTE_W-2:0];
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
          case (st)
            F_ID: st <= id_ok(nb, dev_addr) ? F_INSTR : F_SKIP;
            F_INSTR: begin
              cmd_op  <= nb[7:4];
              cmd_reg <= nb[3:2];
              cmd_pot <= nb[1:0];
              kind    <= op_kind(nb);
              case (op_kind(nb))
                K_XFER:                 begin st <= F_DONE; commit <= 1'b1; end
                K_WRITE, K_READ, K_STAT: st <= F_DATA;
                K_STEP:                 st <= F_STEP;
                default:                st <= F_SKIP;
              endcase
            end
            default: begin
              if (kind == K_WRITE) begin
                cmd_data <= nb[DATA_W-1:0];
                commit   <= 1'b1;
              end
              st <= F_DONE;
            end
          endcase
        end
      end
    end
  end

  assign rd_active = (st == F_DATA) && (kind == K_READ || kind == K_STAT);
  assign so_en     = rd_active && !paused;

  spipot_sodrv #(.W(BYTE_W)) u_so (
    .clk(clk), .rst_n(rst_n), .active(rd_active), .shift(sck_fo),
    .load_val(out_byte(kind == K_STAT, wip, rd_data)), .so_bit(so));
endmodule

// File: rtl/spipot_front_chk.sv
module spipot_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise,
  input logic       csn_s,
  input logic       paused,
  input logic       sck_go,
  input logic       sck_fo,
  input logic       so,
  input logic       so_en,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       step_pulse
);
  a_r3_commit_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise));

  a_r10_commit_ops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_op inside {4'b0001, 4'b1000, 4'b1010, 4'b1100, 4'b1101, 4'b1110});

  a_r8_so_quiet_paused: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> (!paused && !csn_s));

  a_r7_step_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $past(sck_go));

  a_r5_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(sck_fo));

  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, step_pulse}));
endmodule

bind spipot_front spipot_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .csn_s(csn_s), .paused(paused),
  .sck_go(sck_go), .sck_fo(sck_fo), .so(so), .so_en(so_en),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .step_pulse(step_pulse));

// File: tb/sim_spipot_front.sv
module sim_spipot_front;
  localparam int HP = 6;
  localparam logic [1:0] ADDR = 2'b10;

  logic clk = 0, rst_n = 0, sck = 0, si = 0, cs_n = 0, hold_n = 1, wip = 0;
  logic [1:0] dev_addr = ADDR;
  logic [5:0] rd_data;
  logic so, so_en, cmd_valid, step_pulse, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [5:0] cmd_data;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [14:0] cq[$];
  logic [2:0]  sq[$];

  always #2 clk = ~clk;

  // Bench back end: stored value derived from the selects.
  function automatic logic [5:0] be_val(input logic [1:0] p, input logic [1:0] r);
    return {p ^ 2'b10, r, p[0], 1'b1};
  endfunction
  assign rd_data = be_val(cmd_pot, cmd_reg);

  spipot_front u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
    .hold_n(hold_n), .dev_addr(dev_addr), .rd_data(rd_data), .wip(wip), .so(so),
    .so_en(so_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .cmd_pot(cmd_pot), .cmd_data(cmd_data), .step_pulse(step_pulse), .step_up(step_up));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Every-clock comparison of strobes against the expected event queues.
  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      if (cq.size() == 0) chk(0, "R10 unexpected commit", int'(cmd_op), 0);
      else begin
        logic [14:0] e;
        logic [13:0] a;
        e = cq.pop_front();
        a = {cmd_op, cmd_reg, cmd_pot, e[14] ? cmd_data : e[5:0]};
        chk(a == e[13:0], "R2 R3 R4 commit fields", int'(a), int'(e[13:0]));
      end
    end
    if (step_pulse) begin
      if (sq.size() == 0) chk(0, "R7 unexpected step", int'(step_up), 0);
      else begin
        logic [2:0] s;
        s = sq.pop_front();
        chk({cmd_pot, step_up} == s, "R7 step pot/direction", int'({cmd_pot, step_up}), int'(s));
      end
    end
  end

  task automatic expect_cmd(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                            input logic [5:0] d, input bit care);
    cq.push_back({care, op, r, p, d});
  endtask

  // One serial bit; when rdchk is set the host samples SO before the rise.
  task automatic sbit(input logic b, input bit rdchk, input logic eb, input string req);
    si = b;
    tick(HP);
    if (rdchk) chk(so_en === 1'b1 && so === eb, req, int'({so_en, so}), int'({1'b1, eb}));
    else       chk(so_en === 1'b0, {req, " no drive"}, int'(so_en), 0);
    sck = 1;
    tick(HP);
    sck = 0;
  endtask

  task automatic sbyte(input logic [7:0] b, input bit rdchk, input logic [7:0] exp, input string req);
    for (int i = 7; i >= 0; i--) sbit(b[i], rdchk, exp[i], req);
  endtask

  task automatic cs_go;
    cs_n = 0;
    tick(HP);
  endtask

  task automatic cs_stop(input string req);
    tick(HP);
    cs_n = 1;
    tick(12);
    chk(cq.size() == 0 && sq.size() == 0, {req, " events drained"}, cq.size() + sq.size(), 0);
    chk(so_en === 1'b0, {req, " so_en low when deselected"}, int'(so_en), 0);
    tick(HP);
  endtask

  function automatic logic [7:0] idb(input logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1;
    tick(4);
    // R9: reset state, then bytes with select held low since reset are ignored
    chk(so_en === 0 && cmd_valid === 0 && step_pulse === 0, "R9 reset outputs", int'(so_en), 0);
    sbyte(idb(ADDR), 0, 8'h0, "R9");
    sbyte(8'b1101_01_10, 0, 8'h0, "R9");
    cs_stop("R9 no op before select falls");

    // R3: single transfer and global transfer
    cs_go; sbyte(idb(ADDR), 0, 0, "R3"); sbyte(8'b1101_01_10, 0, 0, "R3");
    expect_cmd(4'b1101, 2'b01, 2'b10, 0, 0); cs_stop("R3 xfer");
    cs_go; sbyte(idb(ADDR), 0, 0, "R3"); sbyte(8'b1000_11_00, 0, 0, "R3");
    expect_cmd(4'b1000, 2'b11, 2'b00, 0, 0); cs_stop("R3 global");

    // R4: write wiper and write stored register
    cs_go; sbyte(idb(ADDR), 0, 0, "R4"); sbyte(8'b1010_00_01, 0, 0, "R4");
    sbyte(8'h2D, 0, 0, "R4"); expect_cmd(4'b1010, 2'b00, 2'b01, 6'h2D, 1); cs_stop("R4 wcr");
    cs_go; sbyte(idb(ADDR), 0, 0, "R4"); sbyte(8'b1100_10_11, 0, 0, "R4");
    sbyte(8'h15, 0, 0, "R4"); expect_cmd(4'b1100, 2'b10, 2'b11, 6'h15, 1); cs_stop("R4 dr");

    // R5: reads shift out 00 + value
    cs_go; sbyte(idb(ADDR), 0, 0, "R5"); sbyte(8'b1001_00_00, 0, 0, "R5");
    sbyte(8'h00, 1, {2'b00, be_val(2'b00, 2'b00)}, "R5 read wcr"); cs_stop("R5");
    cs_go; sbyte(idb(ADDR), 0, 0, "R5"); sbyte(8'b1011_01_11, 0, 0, "R5");
    sbyte(8'h00, 1, {2'b00, be_val(2'b11, 2'b01)}, "R5 read dr"); cs_stop("R5");

    // R6: status byte with both flag values
    wip = 1;
    cs_go; sbyte(idb(ADDR), 0, 0, "R6"); sbyte(8'b0101_0001, 0, 0, "R6");
    sbyte(8'h00, 1, 8'h01, "R6 status busy"); cs_stop("R6");
    wip = 0;
    cs_go; sbyte(idb(ADDR), 0, 0, "R6"); sbyte(8'b0101_0001, 0, 0, "R6");
    sbyte(8'h00, 1, 8'h00, "R6 status idle"); cs_stop("R6");

    // R7: step stream on pot 2
    cs_go; sbyte(idb(ADDR), 0, 0, "R7"); sbyte(8'b0010_00_10, 0, 0, "R7");
    begin
      logic [4:0] pat = 5'b11010;
      for (int i = 4; i >= 0; i--) begin
        sq.push_back({2'b10, pat[i]});
        sbit(pat[i], 0, 0, "R7");
      end
    end
    cs_stop("R7 steps");

    // R1: wrong address, wrong type bits, wrong reserved bits
    cs_go; sbyte(idb(2'b01), 0, 0, "R1"); sbyte(8'b1010_00_01, 0, 0, "R1");
    sbyte(8'h11, 0, 0, "R1"); cs_stop("R1 address mismatch");
    cs_go; sbyte(8'b0111_00_10, 0, 0, "R1"); sbyte(8'b1001_00_00, 0, 0, "R1");
    sbyte(8'h00, 0, 0, "R1 read refused"); cs_stop("R1 type mismatch");
    cs_go; sbyte(8'b0101_01_10, 0, 0, "R1"); sbyte(8'b1101_00_00, 0, 0, "R1");
    cs_stop("R1 reserved bits");

    // R10: short write, undefined opcode, transfer cut mid-byte
    cs_go; sbyte(idb(ADDR), 0, 0, "R10"); sbyte(8'b1100_00_00, 0, 0, "R10");
    cs_stop("R10 short write");
    cs_go; sbyte(idb(ADDR), 0, 0, "R10"); sbyte(8'b0011_00_00, 0, 0, "R10");
    sbyte(8'h05, 0, 0, "R10"); cs_stop("R10 undefined op");
    cs_go; sbyte(idb(ADDR), 0, 0, "R10");
    for (int i = 0; i < 5; i++) sbit(1'b1, 0, 0, "R10");
    cs_stop("R10 cut instruction");

    // R8: pause in the middle of a read, with stray clocks while paused
    cs_go; sbyte(idb(ADDR), 0, 0, "R8"); sbyte(8'b1011_10_01, 0, 0, "R8");
    begin
      logic [7:0] e = {2'b00, be_val(2'b01, 2'b10)};
      for (int i = 7; i >= 5; i--) sbit(1'b0, 1, e[i], "R8 before pause");
      hold_n = 0; tick(HP);
      chk(so_en === 1'b0, "R8 so_en low while paused", int'(so_en), 0);
      for (int k = 0; k < 3; k++) begin sck = 1; tick(HP); sck = 0; tick(HP); end
      chk(so_en === 1'b0, "R8 still paused", int'(so_en), 0);
      hold_n = 1; tick(HP);
      for (int i = 4; i >= 0; i--) sbit(1'b0, 1, e[i], "R8 after resume");
    end
    cs_stop("R8 read");
    // R8: pause in a write data byte keeps the value intact
    cs_go; sbyte(idb(ADDR), 0, 0, "R8"); sbyte(8'b1010_00_11, 0, 0, "R8");
    sbit(0, 0, 0, "R8"); sbit(0, 0, 0, "R8"); sbit(1, 0, 0, "R8");
    hold_n = 0; tick(HP); si = 0;
    for (int k = 0; k < 2; k++) begin sck = 1; tick(HP); sck = 0; tick(HP); end
    hold_n = 1; tick(HP);
    sbit(0, 0, 0, "R8"); sbit(1, 0, 0, "R8"); sbit(1, 0, 0, "R8");
    sbit(0, 0, 0, "R8"); sbit(1, 0, 0, "R8");
    expect_cmd(4'b1010, 2'b00, 2'b11, 6'h2D, 1); cs_stop("R8 write");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule